// File: doc/BRIEF.md
# Multiplexed CPU Port with Shared-Memory Arbitration

This block connects an 8-bit multiplexed address/data processor bus to a device's internal storage. The processor presents an address on the shared bus together with a latch strobe. It then raises chip select and a read or write strobe, and on a write it places data on the same bus. Address bit 7 chooses between two targets. When it is clear, the access goes to a small bank of configuration registers, and it completes one cycle after the strobe. When it is set, the low seven address bits are joined with a five-bit page held in the control register to form a 12-bit memory address. A three-bit select field in the same register picks which internal memory that address reaches.

The memories are also used by a TDM switching port, so every processor memory access must compete for a slot. The TDM side has priority. A waiting processor access takes the first slot the TDM side leaves free, and it is forced through once it has waited a bounded number of cycles in which the memory clock ran. Because of this the acknowledge comes back after a variable delay. The acknowledge is an active-low, open-drain-style output. It is driven high while the access waits and driven low on completion. When the strobe ends it is driven high for one cycle, and after that it is released. If the memory-side clock stops, no slot is granted and the acknowledge stays high.

Top module: `cpu_port_arb`

## Requirements
- R1: An address on `ad_in` is captured when `ale` is high. With address bit 7 low, the access targets register `addr[6:0]`. Registers 0..3 read back the last value written to them, and register offsets 4..127 read as zero and ignore writes.
- R2: A register access completes with `ack_n` low exactly one clock after the strobe (`cs` and `rd` or `wr`) is first sampled. This holds even while the TDM port requests every cycle or the memory clock is absent.
- R3: With address bit 7 high, the memory address is `{ctrl[4:0], addr[6:0]}`, and the memory select is `ctrl[7:5]`, where `ctrl` is register 0.
- R4: Selects 0..3 are connection memories and accept writes. Selects 4..7 are data memories and are read-only. A write to one of them completes one clock after the strobe and never issues a memory write, so the stored contents stay unchanged.
- R5: The TDM port has priority. A waiting processor access is granted in the first cycle with the memory clock present and no TDM request. A read then shows `ack_n` low 3 clocks after the strobe plus the number of wait cycles, and a connection-memory write 2 clocks plus the wait cycles.
- R6: If the TDM port requests continuously, the processor access is granted after MAX_WAIT (4) denied cycles with the clock present. In the granting cycle `tdm_gnt` is low.
- R7: While `clk_ok` is low, no memory slot is granted to either side, and `ack_n` stays high with `ack_oe` high.
- R8: `ack_oe` is high from the cycle after the strobe is sampled until one cycle after the strobe ends. In that last cycle `ack_n` is high, and on the following cycle `ack_oe` is low.
- R9: Read data is driven (`ad_oe` high) while `cs` and `rd` stay high after the acknowledge, and it holds stable for that whole time. `ad_oe` is low on writes and whenever the strobe is low.
- R10: After reset, `ack_oe`, `ad_oe` and `mem_en` are low and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address latch strobe |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| ad_in | input | 8 | Shared bus, inbound address or write data |
| ad_out | output | 8 | Shared bus, outbound read data |
| ad_oe | output | 1 | Bus output enable |
| ack_n | output | 1 | Transfer acknowledge, low when complete |
| ack_oe | output | 1 | Acknowledge output enable |
| clk_ok | input | 1 | Memory-side clock present |
| tdm_req | input | 1 | TDM port memory request |
| tdm_we | input | 1 | TDM port write |
| tdm_sel | input | 3 | TDM port memory select |
| tdm_addr | input | 12 | TDM port memory address |
| tdm_wdata | input | 8 | TDM port write data |
| tdm_gnt | output | 1 | TDM port granted this cycle |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write |
| mem_sel | output | 3 | Memory select |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after the access |

## Verification
The hardest case to reach is the forced grant. It needs the TDM port to stay busy for exactly the cycles that the processor access spends waiting, sometimes combined with a stopped memory clock. The bench drives `tdm_req` and `clk_ok` cycle by cycle, counting from the moment the strobe is raised. It sweeps the number of busy cycles past the wait bound and mixes in stall lengths, and it predicts each acknowledge delay arithmetically. Page and select decoding are covered by sweeping all eight selects over several pages and offsets against a patterned memory model.

// File: rtl/cpa_pkg.sv
`timescale 1ns/1ps
package cpa_pkg;

    localparam int DATA_W = 8;
    localparam int LOW_W  = 7;
    localparam int PAGE_W = 5;
    localparam int SEL_W  = 3;
    localparam int MEM_AW = PAGE_W + LOW_W;

    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_WAIT,
        SEQ_CAPT,
        SEQ_DONE,
        SEQ_RELEASE
    } seq_state_e;

    // Control register layout: select in the top bits, page in the bottom bits.
    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [PAGE_W-1:0] page;
    } ctrl_t;

    typedef struct packed {
        logic              we;
        logic [SEL_W-1:0]  sel;
        logic [MEM_AW-1:0] addr;
        byte_t             wdata;
    } mem_cmd_t;

    function automatic logic sel_writable(input logic [SEL_W-1:0] sel, input int cm_count);
        return int'(sel) < cm_count;
    endfunction

    function automatic logic [MEM_AW-1:0] join_addr(input ctrl_t c, input logic [LOW_W-1:0] low);
        return {c.page, low};
    endfunction

endpackage

// File: rtl/cpa_regs.sv
`timescale 1ns/1ps
module cpa_regs
    import cpa_pkg::*;
#(
    parameter int REG_COUNT = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  ale,
    input  byte_t ad_in,
    input  logic  reg_we,
    input  byte_t reg_wdata,
    output byte_t addr_q,
    output ctrl_t ctrl,
    output byte_t reg_rdata
);
    localparam int IDX_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;
    localparam logic [LOW_W-1:0] REG_LIMIT = LOW_W'(REG_COUNT);

    byte_t            bank [REG_COUNT];
    logic [LOW_W-1:0] reg_off;
    logic [IDX_W-1:0] idx;
    logic             hit;

    assign reg_off = addr_q[LOW_W-1:0];
    assign idx     = reg_off[IDX_W-1:0];
    assign hit     = reg_off < REG_LIMIT;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (ale) begin
            addr_q <= ad_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_COUNT; i++) begin
                bank[i] <= '0;
            end
        end else if (reg_we && hit) begin
            for (int i = 0; i < REG_COUNT; i++) begin
                if (idx == IDX_W'(i)) begin
                    bank[i] <= reg_wdata;
                end
            end
        end
    end

    assign reg_rdata = hit ? bank[idx] : '0;
    assign ctrl      = ctrl_t'(bank[0]);

endmodule

// File: rtl/cpa_arbiter.sv
`timescale 1ns/1ps
module cpa_arbiter #(
    parameter int MAX_WAIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clk_ok,
    input  logic cpu_req,
    input  logic tdm_req,
    output logic cpu_gnt,
    output logic tdm_gnt
);
    localparam int WAIT_W = $clog2(MAX_WAIT + 1);
    localparam logic [WAIT_W-1:0] WAIT_LIMIT = WAIT_W'(MAX_WAIT);

    logic [WAIT_W-1:0] denied;
    logic              forced;

    assign forced  = denied == WAIT_LIMIT;
    assign cpu_gnt = clk_ok && cpu_req && (forced || !tdm_req);
    assign tdm_gnt = clk_ok && tdm_req && !cpu_gnt;

    // Counts slots the processor lost while the memory clock was running.
    always_ff @(posedge clk) begin
        if (rst) begin
            denied <= '0;
        end else if (!cpu_req || cpu_gnt) begin
            denied <= '0;
        end else if (clk_ok && !forced) begin
            denied <= denied + 1'b1;
        end
    end

endmodule

// File: rtl/cpa_seq.sv
`timescale 1ns/1ps
module cpa_seq
    import cpa_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cs,
    input  logic  rd,
    input  logic  wr,
    input  byte_t ad_in,
    input  logic  is_mem,
    input  logic  writable,
    input  logic  cpu_gnt,
    input  byte_t mem_rdata,
    input  byte_t reg_rdata,
    output logic  cpu_req,
    output logic  cpu_we,
    output logic  reg_we,
    output byte_t wdata_q,
    output logic  ack_n,
    output logic  ack_oe,
    output logic  ad_oe,
    output byte_t ad_out
);
    seq_state_e state;
    logic       strobe;
    logic       is_wr_q;
    byte_t      rdata_q;

    assign strobe = cs && (rd || wr);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_IDLE;
            is_wr_q <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (strobe) begin
                        is_wr_q <= wr;
                        wdata_q <= ad_in;
                        if (!is_mem) begin
                            rdata_q <= reg_rdata;
                            state   <= SEQ_DONE;
                        end else if (wr && !writable) begin
                            state <= SEQ_DONE;
                        end else begin
                            state <= SEQ_WAIT;
                        end
                    end
                end
                SEQ_WAIT: begin
                    if (!strobe) begin
                        state <= SEQ_RELEASE;
                    end else if (cpu_gnt) begin
                        state <= is_wr_q ? SEQ_DONE : SEQ_CAPT;
                    end
                end
                SEQ_CAPT: begin
                    rdata_q <= mem_rdata;
                    state   <= SEQ_DONE;
                end
                SEQ_DONE: begin
                    if (!strobe) begin
                        state <= SEQ_RELEASE;
                    end
                end
                SEQ_RELEASE: state <= SEQ_IDLE;
                default:     state <= SEQ_IDLE;
            endcase
        end
    end

    assign cpu_req = (state == SEQ_WAIT) && strobe;
    assign cpu_we  = is_wr_q;
    assign reg_we  = (state == SEQ_IDLE) && strobe && wr && !is_mem;
    assign ack_oe  = state != SEQ_IDLE;
    assign ack_n   = state != SEQ_DONE;
    assign ad_oe   = (state == SEQ_DONE) && cs && rd && !is_wr_q;
    assign ad_out  = rdata_q;

endmodule

// File: rtl/cpu_port_arb.sv
`timescale 1ns/1ps
module cpu_port_arb
    import cpa_pkg::*;
#(
    parameter int MAX_WAIT  = 4,
    parameter int REG_COUNT = 4,
    parameter int CM_COUNT  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ale,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [7:0]        ad_in,
    output logic [7:0]        ad_out,
    output logic              ad_oe,
    output logic              ack_n,
    output logic              ack_oe,
    input  logic              clk_ok,
    input  logic              tdm_req,
    input  logic              tdm_we,
    input  logic [2:0]        tdm_sel,
    input  logic [11:0]       tdm_addr,
    input  logic [7:0]        tdm_wdata,
    output logic              tdm_gnt,
    output logic              mem_en,
    output logic              mem_we,
    output logic [2:0]        mem_sel,
    output logic [11:0]       mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    byte_t    addr_q;
    ctrl_t    ctrl;
    byte_t    reg_rdata;
    byte_t    wdata_q;
    logic     reg_we;
    logic     cpu_req;
    logic     cpu_gnt;
    logic     cpu_we;
    logic     is_mem;
    logic     writable;
    mem_cmd_t cpu_cmd;
    mem_cmd_t tdm_cmd;
    mem_cmd_t sel_cmd;

    assign is_mem   = addr_q[DATA_W-1];
    assign writable = sel_writable(ctrl.sel, CM_COUNT);

    cpa_regs #(.REG_COUNT(REG_COUNT)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .ale       (ale),
        .ad_in     (ad_in),
        .reg_we    (reg_we),
        .reg_wdata (ad_in),
        .addr_q    (addr_q),
        .ctrl      (ctrl),
        .reg_rdata (reg_rdata)
    );

    cpa_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cs        (cs),
        .rd        (rd),
        .wr        (wr),
        .ad_in     (ad_in),
        .is_mem    (is_mem),
        .writable  (writable),
        .cpu_gnt   (cpu_gnt),
        .mem_rdata (mem_rdata),
        .reg_rdata (reg_rdata),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .reg_we    (reg_we),
        .wdata_q   (wdata_q),
        .ack_n     (ack_n),
        .ack_oe    (ack_oe),
        .ad_oe     (ad_oe),
        .ad_out    (ad_out)
    );

    cpa_arbiter #(.MAX_WAIT(MAX_WAIT)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .clk_ok  (clk_ok),
        .cpu_req (cpu_req),
        .tdm_req (tdm_req),
        .cpu_gnt (cpu_gnt),
        .tdm_gnt (tdm_gnt)
    );

    assign cpu_cmd = '{we: cpu_we, sel: ctrl.sel,
                       addr: join_addr(ctrl, addr_q[LOW_W-1:0]), wdata: wdata_q};
    assign tdm_cmd = '{we: tdm_we, sel: tdm_sel, addr: tdm_addr, wdata: tdm_wdata};
    assign sel_cmd = cpu_gnt ? cpu_cmd : tdm_cmd;

    assign mem_en    = cpu_gnt || tdm_gnt;
    assign mem_we    = mem_en && sel_cmd.we;
    assign mem_sel   = sel_cmd.sel;
    assign mem_addr  = sel_cmd.addr;
    assign mem_wdata = sel_cmd.wdata;

endmodule

// File: rtl/cpa_checker.sv
`timescale 1ns/1ps
module cpa_checker #(
    parameter int MAX_WAIT = 4,
    parameter int CM_COUNT = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       clk_ok,
    input logic       tdm_req,
    input logic       tdm_gnt,
    input logic       cpu_req,
    input logic       cpu_gnt,
    input logic       mem_en,
    input logic       mem_we,
    input logic [2:0] mem_sel,
    input logic       ack_n,
    input logic       ack_oe,
    input logic       ad_oe,
    input logic       cs,
    input logic       rd
);
    logic [15:0] wait_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_c <= '0;
        end else if (!cpu_req || cpu_gnt) begin
            wait_c <= '0;
        end else if (clk_ok) begin
            wait_c <= wait_c + 16'd1;
        end
    end

    // R5
    cpu_first_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && clk_ok && !tdm_req) |-> cpu_gnt);

    // R6
    wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
        32'(wait_c) <= MAX_WAIT);

    // R6
    single_owner_chk: assert property (@(posedge clk) disable iff (rst)
        !(cpu_gnt && tdm_gnt));

    // R7
    no_clock_no_slot_chk: assert property (@(posedge clk) disable iff (rst)
        !clk_ok |-> !mem_en);

    // R4
    data_mem_readonly_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_we && cpu_gnt) |-> (32'(mem_sel) < CM_COUNT));

    // R8
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_oe && $rose(ack_n)) |=> !ack_oe);

    // R8
    ack_driven_chk: assert property (@(posedge clk) disable iff (rst)
        !ack_n |-> ack_oe);

    // R9
    bus_drive_chk: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> (cs && rd && !ack_n));

endmodule

bind cpu_port_arb cpa_checker #(.MAX_WAIT(MAX_WAIT), .CM_COUNT(CM_COUNT)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .clk_ok  (clk_ok),
    .tdm_req (tdm_req),
    .tdm_gnt (tdm_gnt),
    .cpu_req (cpu_req),
    .cpu_gnt (cpu_gnt),
    .mem_en  (mem_en),
    .mem_we  (mem_we),
    .mem_sel (mem_sel),
    .ack_n   (ack_n),
    .ack_oe  (ack_oe),
    .ad_oe   (ad_oe),
    .cs      (cs),
    .rd      (rd)
);

// File: tb/tb_cpu_port_arb.sv
`timescale 1ns/1ps
module tb_cpu_port_arb;
    localparam int MW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ale = 1'b0, cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [7:0]  ad_in = '0;
    logic [7:0]  ad_out;
    logic        ad_oe, ack_n, ack_oe;
    logic        clk_ok = 1'b1;
    logic        tdm_req = 1'b0;
    logic        tdm_gnt;
    logic        mem_en, mem_we;
    logic [2:0]  mem_sel;
    logic [11:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    int vectors = 0;
    int miscompares = 0;
    int dm_writes = 0;
    bit finished = 0;

    logic [7:0] mem [8][4096];

    always #2.5 clk = ~clk;

    cpu_port_arb #(.MAX_WAIT(MW)) dut (
        .clk(clk), .rst(rst), .ale(ale), .cs(cs), .rd(rd), .wr(wr),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .ack_n(ack_n), .ack_oe(ack_oe),
        .clk_ok(clk_ok), .tdm_req(tdm_req), .tdm_we(1'b0), .tdm_sel(3'd0),
        .tdm_addr(12'd0), .tdm_wdata(8'd0), .tdm_gnt(tdm_gnt),
        .mem_en(mem_en), .mem_we(mem_we), .mem_sel(mem_sel), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] pat(input int sel, input int addr);
        return 8'(sel * 29 + addr * 7 + (addr >> 5));
    endfunction

    // Wait index at which the processor gets its slot (R5, R6, R7).
    function automatic int grant_idx(input int busy, input int stall);
        if (busy <= stall) return stall;
        return (busy < stall + MW) ? busy : stall + MW;
    endfunction

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                mem[mem_sel][mem_addr] <= mem_wdata;
                if (mem_sel >= 3'd4) dm_writes++;
            end
            mem_rdata <= mem[mem_sel][mem_addr];
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cpu_cycle(input logic [7:0] addr, input bit is_wr, input logic [7:0] wd,
                             input int busy, input int stall, input int hold,
                             output logic [7:0] rdv, output int lat);
        @(negedge clk);
        ale = 1'b1; ad_in = addr;
        @(negedge clk);
        ale = 1'b0; cs = 1'b1; rd = !is_wr; wr = is_wr; ad_in = wd;
        tdm_req = (busy > 0); clk_ok = !(stall > 0);
        lat = 0;
        while (1) begin
            @(negedge clk);
            lat++;
            if (!ack_n || lat > 60) break;
            chk("R8/R7 ack driven high while waiting", ack_oe, 1);
            tdm_req = (lat <= busy);
            clk_ok = !(lat <= stall);
        end
        tdm_req = 1'b0; clk_ok = 1'b1;
        rdv = ad_out;
        chk("R9 bus drive at ack", ad_oe, is_wr ? 0 : 1);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk("R8 ack held low", ack_n, 0);
            chk("R9 data held", ad_out, rdv);
            chk("R9 oe held", ad_oe, is_wr ? 0 : 1);
        end
        cs = 1'b0; rd = 1'b0; wr = 1'b0;
        @(negedge clk);
        chk("R8 release cycle", {ack_oe, ack_n}, 2'b11);
        chk("R9 bus released", ad_oe, 0);
        @(negedge clk);
        chk("R8 ack floated", ack_oe, 0);
    endtask

    task automatic reg_rd(input int a, input int exp, input int busy, input int stall);
        logic [7:0] d; int l;
        cpu_cycle(8'(a), 1'b0, 8'h00, busy, stall, 0, d, l);
        chk("R1 register read", d, exp);
        chk("R2 register latency", l, 1);
    endtask

    task automatic reg_wr(input int a, input int v);
        logic [7:0] d; int l;
        cpu_cycle(8'(a), 1'b1, 8'(v), 0, 0, 0, d, l);
        chk("R2 register write latency", l, 1);
    endtask

    task automatic mem_rd(input int low, input int exp, input int busy, input int stall, input int hold);
        logic [7:0] d; int l;
        cpu_cycle(8'(8'h80 | low), 1'b0, 8'h00, busy, stall, hold, d, l);
        chk("R3 memory read data", d, exp);
        chk("R5 read latency", l, 3 + grant_idx(busy, stall));
    endtask

    initial begin
        logic [7:0] d;
        int l;
        for (int s = 0; s < 8; s++)
            for (int a = 0; a < 4096; a++)
                mem[s][a] = pat(s, a);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 ack_oe", ack_oe, 0);
        chk("R10 ad_oe", ad_oe, 0);
        chk("R10 mem_en", mem_en, 0);
        for (int r = 0; r < 4; r++) reg_rd(r, 0, 0, 0);

        // R1 / R2: register bank, latency unaffected by TDM or stall
        for (int r = 1; r < 4; r++) reg_wr(r, 8'h3C + r * 17);
        for (int r = 1; r < 4; r++) reg_rd(r, 8'h3C + r * 17, r, 4 - r);
        for (int a = 4; a < 128; a++) begin
            reg_wr(a, 8'hA5);
            reg_rd(a, 0, 0, 0);
        end
        for (int r = 1; r < 4; r++) reg_rd(r, 8'h3C + r * 17, 0, 0);

        // R3: page and select decode sweep
        for (int s = 0; s < 8; s++) begin
            for (int pi = 0; pi < 3; pi++) begin
                int pg;
                pg = (pi == 0) ? 0 : (pi == 1) ? 5 : 31;
                reg_wr(0, (s << 5) | pg);
                reg_rd(0, (s << 5) | pg, 0, 0);
                for (int li = 0; li < 4; li++) begin
                    int lo;
                    lo = (li == 0) ? 0 : (li == 1) ? 1 : (li == 2) ? 64 : 127;
                    mem_rd(lo, pat(s, (pg << 7) | lo), 0, 0, 0);
                end
            end
        end

        // R4: connection memories writable, data memories read-only
        for (int s = 0; s < 8; s++) begin
            reg_wr(0, (s << 5) | 9);
            cpu_cycle(8'h80 | 8'd33, 1'b1, 8'(8'hC1 + s), 0, 0, 0, d, l);
            chk("R4 write latency", l, (s < 4) ? 2 : 1);
            mem_rd(33, (s < 4) ? 8'(8'hC1 + s) : pat(s, (9 << 7) | 33), 0, 0, 0);
        end
        chk("R4 no data-memory write issued", dm_writes, 0);

        // R5 / R6: TDM busy sweep past the wait bound
        reg_wr(0, (2 << 5) | 3);
        for (int b = 0; b < 9; b++) mem_rd(b, pat(2, (3 << 7) | b), b, 0, 0);

        // R7: clock stalls, alone and with TDM traffic
        for (int s = 1; s < 6; s++) mem_rd(10 + s, pat(2, (3 << 7) | (10 + s)), 0, s, 0);
        mem_rd(20, pat(2, (3 << 7) | 20), 5, 2, 0);
        mem_rd(21, pat(2, (3 << 7) | 21), 2, 3, 0);
        mem_rd(22, pat(2, (3 << 7) | 22), 9, 1, 0);

        // R9: read data held while the strobe stays up
        mem_rd(40, pat(2, (3 << 7) | 40), 0, 0, 3);
        reg_wr(0, (0 << 5) | 1);
        cpu_cycle(8'h80 | 8'd50, 1'b1, 8'h5A, 2, 0, 2, d, l);
        chk("R6 write latency with busy TDM", l, 2 + grant_idx(2, 0));
        mem_rd(50, 8'h5A, 0, 0, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule